// File: doc/BRIEF.md
# Programmable Strobe Generator with Access Timeout

This block sits in a peripheral bus bridge and shapes the access strobes seen by slow peripherals. It runs from the bridge clock and holds one control register. That register carries a 4-bit wait-state factor for each of two strobe lines and an 8-bit timeout field. A factor of k makes its strobe pulse once every k+1 bridge clocks while an access is in progress.

An access begins with `cyc_start` and ends when the peripheral raises `cyc_done`. When the access begins, the block latches both factors and loads a down-counter from the timeout field. If the peripheral has not completed the access by the time that counter runs out, the block drops the access. It then raises a one-clock `abort` toward the processor. Address decoding and data movement are handled elsewhere.

Top module: `strobe_timeout_gen`

## Requirements
- R1: While `rst_n` is low and right after it rises, `busy`, both `strb` bits and `abort` are 0, and the control register reads as all zeros.
- R2: `cyc_start` seen at a clock edge while `busy` is 0 makes `busy` 1 after that edge. `cyc_start` while `busy` is 1 is ignored.
- R3: Control bits [3:0] hold the factor of strobe 0 and bits [7:4] hold the factor of strobe 1. With factor k, counting busy cycles from 1, `strb[i]` is 1 in exactly the busy cycles whose number is a multiple of k+1.
- R4: Factor 0 holds the strobe high in every busy cycle. Factor 15 pulses it once every 16 busy cycles.
- R5: `cyc_done` in a busy cycle makes `busy` 0 after that edge, with no `abort`.
- R6: Control bits [15:8] hold the timeout T, which allows N=T busy cycles for T in 1..255 and N=256 for T=0. If `cyc_done` has not come in busy cycles 1..N, `busy` falls after busy cycle N. In the first idle cycle that follows, `abort` is 1 for exactly one clock.
- R7: `cyc_done` in busy cycle N, the cycle in which the counter reaches zero, counts as a normal completion: `busy` falls and `abort` stays 0.
- R8: `cyc_done` while `busy` is 0 has no effect. `busy` stays 0 and `abort` stays 0.
- R9: Both strobe bits are 0 whenever `busy` is 0.
- R10: A control write with `cfg_we` takes effect at the next edge. A write during an access does not change the factors or the timeout of that access; it applies from the next start onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 16 | Control register write data |
| cyc_start | input | 1 | Request to begin a bus access |
| cyc_done | input | 1 | Peripheral completes the access |
| busy | output | 1 | Access in progress |
| strb | output | 2 | Divided access strobes, one bit per line |
| abort | output | 1 | One-clock pulse when an access times out |

## Verification
The bench builds the block with its default parameters: two strobe lines, 4-bit factors and an 8-bit timeout field. This makes factor 15 reachable, and a timeout field of 0 reaches the full 256-cycle limit within a short run. A behavioural model in the bench counts busy cycles with plain integers. It predicts each strobe by modular arithmetic on that count, and it predicts an abort by comparing the count with the decoded limit. The bench compares the model with the design on every clock, through directed cases for each boundary and through a long stretch of random traffic.

// File: rtl/strobe_timeout_gen.sv
module strobe_timeout_gen #(
  parameter int NUM_STB = 2,
  parameter int FAC_W   = 4,
  parameter int TMO_W   = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [NUM_STB*FAC_W+TMO_W-1:0]       cfg_wdata,
  input  logic                                 cyc_start,
  input  logic                                 cyc_done,
  output logic                                 busy,
  output logic [NUM_STB-1:0]                   strb,
  output logic                                 abort
);
  localparam int CFG_W = NUM_STB*FAC_W + TMO_W;
  localparam int TMO_LSB = NUM_STB*FAC_W;
  localparam int TCW = TMO_W + 1;
  localparam logic [TCW-1:0] TMAX = TCW'(1) << TMO_W;

  logic [CFG_W-1:0] cfg_q;
  logic [TCW-1:0]   tcnt;
  logic [TMO_W-1:0] tmo_fld;
  logic [TCW-1:0]   tmo_load;
  logic             start_ok, expire;

  assign tmo_fld  = cfg_q[TMO_LSB +: TMO_W];
  assign tmo_load = (tmo_fld == '0) ? TMAX : {1'b0, tmo_fld};
  assign start_ok = !busy && cyc_start;
  assign expire   = busy && !cyc_done && (tcnt == TCW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      tcnt  <= '0;
      abort <= 1'b0;
    end else begin
      abort <= expire;
      if (start_ok) begin
        busy <= 1'b1;
        tcnt <= tmo_load;
      end else if (busy) begin
        if (cyc_done || expire) busy <= 1'b0;
        else tcnt <= tcnt - TCW'(1);
      end
    end
  end

  for (genvar i = 0; i < NUM_STB; i++) begin : g_stb
    logic [FAC_W-1:0] fac_q, dcnt;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fac_q <= '0;
        dcnt  <= '0;
      end else if (start_ok) begin
        fac_q <= cfg_q[i*FAC_W +: FAC_W];
        dcnt  <= '0;
      end else if (busy) begin
        dcnt <= (dcnt == fac_q) ? '0 : dcnt + FAC_W'(1);
      end
    end
    assign strb[i] = busy && (dcnt == fac_q);
  end

  assert_abort_leaves_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !busy);
  assert_abort_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);
  assert_abort_needs_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort) |-> $past(busy));
  assert_done_no_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc_done) |=> !abort && !busy);
  assert_idle_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (strb == '0));
  assert_idle_done_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cyc_start) |=> !busy && !abort);
  assert_start_enters_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cyc_start) |=> busy);
  assert_tcnt_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tcnt != '0) && (tcnt <= TMAX));
endmodule

// File: tb/strobe_timeout_gen_bench.sv
module strobe_timeout_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        cyc_start = 1'b0;
  logic        cyc_done = 1'b0;
  logic        busy, abort;
  logic [1:0]  strb;

  strobe_timeout_gen u_strobe_timeout_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cyc_start(cyc_start), .cyc_done(cyc_done),
    .busy(busy), .strb(strb), .abort(abort)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  int m_cfg = 0, m_busy = 0, m_idx = 0, m_lim = 0, m_abort = 0;
  int m_fac[2] = '{0, 0};
  string cur_req = "R1";

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cfg = 0; m_busy = 0; m_idx = 0; m_abort = 0;
    end else begin
      m_abort = 0;
      if (!m_busy) begin
        if (cyc_start) begin
          m_busy = 1; m_idx = 1;
          m_lim = ((m_cfg >> 8) & 255) == 0 ? 256 : ((m_cfg >> 8) & 255);
          m_fac[0] = m_cfg & 15; m_fac[1] = (m_cfg >> 4) & 15;
        end
      end else if (cyc_done) m_busy = 0;
      else if (m_idx == m_lim) begin m_busy = 0; m_abort = 1; end
      else m_idx++;
      if (cfg_we) m_cfg = cfg_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    int e0, e1;
    e0 = m_busy && (m_idx % (m_fac[0] + 1) == 0);
    e1 = m_busy && (m_idx % (m_fac[1] + 1) == 0);
    chk(busy == m_busy, {"R2/", cur_req, " busy"}, busy, m_busy);
    chk(strb[0] == e0, {"R3/", cur_req, " strb0"}, strb[0], e0);
    chk(strb[1] == e1, {"R3/", cur_req, " strb1"}, strb[1], e1);
    chk(abort == m_abort, {"R6/", cur_req, " abort"}, abort, m_abort);
  end

  task automatic step(input bit st, input bit dn);
    cyc_start = st; cyc_done = dn;
    @(negedge clk);
    cyc_start = 1'b0; cyc_done = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic wr(input int v);
    cfg_we = 1'b1; cfg_wdata = 16'(v);
    step(0, 0);
  endtask

  task automatic run_until_idle(input int done_at);
    for (int k = 0; k < 400 && m_busy; k++) step(0, m_idx == done_at);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk(busy == 0 && strb == 0 && abort == 0, "R1 reset outputs", {busy, strb, abort}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && strb == 0 && abort == 0, "R1 after reset", {busy, strb, abort}, 0);
    cur_req = "R9"; step(0, 0);
    cur_req = "R4"; wr(16'h00F0);
    step(1, 0); run_until_idle(-1);
    cur_req = "R6"; step(0, 0);
    cur_req = "R3"; wr(16'h0A53);
    step(1, 0); run_until_idle(7);
    cur_req = "R5"; step(1, 0); step(0, 1); step(0, 0);
    cur_req = "R7"; wr(16'h0A21);
    step(1, 0); run_until_idle(10);
    step(0, 0);
    chk(busy == 0 && abort == 0, "R7 done at limit", {busy, abort}, 0);
    cur_req = "R8";
    for (int k = 0; k < 4; k++) step(0, 1);
    chk(busy == 0 && abort == 0, "R8 idle done", {busy, abort}, 0);
    cur_req = "R6"; wr(16'h0100);
    step(1, 0); run_until_idle(-1); step(0, 0);
    cur_req = "R10"; wr(16'h0512);
    step(1, 0); wr(16'h03FF); step(1, 0); run_until_idle(-1);
    step(1, 0); run_until_idle(-1); step(0, 0);
    cur_req = "R2";
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 30) == 0) begin
        cfg_we = 1'b1; cfg_wdata = 16'($urandom_range(0, 65535));
        if ($urandom_range(0, 1) == 0) cfg_wdata[15:8] = 8'($urandom_range(1, 20));
      end
      step($urandom_range(0, 3) == 0, $urandom_range(0, 9) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    mismatched++;
    $display("FAIL watchdog expired: actual %0d expected %0d", cycles, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule